// File: doc/BRIEF.md
# Buck Converter Protection and Power-Good Supervisor

This block is the digital supervisor of a step-down converter. It receives four window-comparator results already digitized from the feedback node: over the 125% over-voltage limit, under the 70% under-voltage limit, under 90% of the set point, and at or above 93% of the set point. It also receives a switching-clock tick, the enable input, a supply under-voltage-lockout flag and a two-bit output-voltage select. From these it produces the power-good output, the soft-start current-limit step, and the latched fault responses. An over-voltage fault forces the low-side switch on. An under-voltage fault or an active lockout forces both gates low.

Soft-start raises the current limit in four equal timed steps. Under-voltage detection is blanked for a fixed number of switching ticks after enable. Each fault must persist for a deglitch time, given in microseconds and converted to system clocks from a clock-frequency parameter, before it latches. The latch then holds until the block is disabled, which happens when enable goes low or the supply lockout is asserted. Any change of the voltage select freezes power-good at its present value and masks both fault detectors for 32 switching ticks. A further change during that window starts the 32 ticks again.

Top module: `pwr_supervisor`

## Requirements
- R1: While `rst` is high, `en_i` is low or `uvlo_i` is high, `pgood_o` is 0, `ilim_step_o` is 0 and `fault_code_o` is 0.
- R2: `ilim_step_o` encodes the soft-start current limit as 0=25%, 1=50%, 2=75% and 3=100%. After enable it increments once for every 128 `sw_tick_i` pulses and stays at 3.
- R3: Soft-start ends after 512 ticks. `pgood_o` stays 0 until then, even if the feedback is in range.
- R4: `udr_i` has no effect on `fault_code_o` until 512 ticks have passed since enable.
- R5: `ovr_i` high for OV_CYC = CLK_HZ*20e-6 consecutive clocks latches `fault_code_o`=1 and `ls_force_o`=1. A shorter run latches nothing.
- R6: `udr_i` high for UV_CYC = CLK_HZ*2.5e-6 consecutive clocks after blanking latches `fault_code_o`=2 and drives `gates_low_o` to 1.
- R7: A latched fault does not change while the block stays enabled, whatever the flags do. The first fault to latch wins, and over-voltage wins if both latch in the same cycle. Disabling the block clears the latch.
- R8: After soft-start, `pgood_o` rises once `above_hi_i`=1 with `ovr_i`=0 has held for PG_CYC = CLK_HZ*2.5e-6 consecutive clocks. Between 90% and 93% the present value is kept.
- R9: A high `pgood_o` falls once `below_lo_i` or `ovr_i` has held for PG_CYC consecutive clocks. A shorter glitch has no effect.
- R10: A change of `vsel_i` holds `pgood_o` and ignores `ovr_i` and `udr_i` for 32 ticks from the last change.
- R11: `gates_low_o` is 1 when `en_i` is low, when `uvlo_i` is high, or when an under-voltage fault is latched.
- R12: `pgood_o` is 0 from the cycle after a fault latches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_tick_i | input | 1 | One-cycle pulse per switching cycle |
| en_i | input | 1 | Converter enable |
| uvlo_i | input | 1 | Supply below lockout threshold |
| vsel_i | input | VSEL_W | Output-voltage select |
| ovr_i | input | 1 | Feedback above 125% |
| udr_i | input | 1 | Feedback below 70% |
| below_lo_i | input | 1 | Feedback below 90% |
| above_hi_i | input | 1 | Feedback at or above 93% |
| pgood_o | output | 1 | Power-good |
| ilim_step_o | output | 2 | Soft-start current-limit step code |
| ls_force_o | output | 1 | Low-side switch forced on (over-voltage latched) |
| gates_low_o | output | 1 | Both gates forced low |
| fault_code_o | output | 2 | Latched fault: 0 none, 1 over-voltage, 2 under-voltage |

## Verification
The bench looks at deglitch runs that end one clock short of the threshold. A counter that does not restart on a broken run, or that is off by one, latches a fault or drops power-good early. It changes the voltage select twice within one mask window and holds a falling-power-good condition and an over-voltage run through the combined window. A mask that does not restart lets power-good fall and the fault latch while the output is still moving. It also offers an under-voltage condition during blanking, a second fault on top of a latched one, and the 90% to 93% band. A design without blanking, without first-fault priority, or without hysteresis would shut down at start-up, overwrite the status, or chatter.

// File: rtl/pwrsup_pkg.sv
package pwrsup_pkg;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_OV   = 2'd1,
        FLT_UV   = 2'd2
    } fault_e;

    typedef struct packed {
        logic ov;
        logic uv;
        logic below_lo;
        logic above_hi;
    } fb_win_t;

    // Converts a delay in tenths of a microsecond to system clock cycles (minimum 1).
    function automatic int unsigned tenths_us_to_cycles(input int unsigned clk_hz,
                                                        input int unsigned tenths);
        logic [63:0] prod;
        prod = (64'(clk_hz) * 64'(tenths)) / 64'd10_000_000;
        if (prod == 64'd0) prod = 64'd1;
        return prod[31:0];
    endfunction

endpackage

// File: rtl/pwrsup_deglitch.sv
module pwrsup_deglitch #(
    parameter int unsigned CYCLES = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic cond,
    output logic fire
);
    localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] run_q;

    assign fire = cond & ~clear & (run_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clear || !cond || fire) begin
            run_q <= '0;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    generate
        if (CYCLES > 1) begin : g_run_chk
            // R9: a fire needs the condition in the previous cycle too
            assert_fire_after_run_R9: assert property (@(posedge clk) disable iff (rst)
                fire |-> $past(cond));
        end
    endgenerate

endmodule

// File: rtl/pwrsup_tick_timer.sv
module pwrsup_tick_timer #(
    parameter int unsigned TICKS = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic load,
    input  logic tick,
    output logic busy
);
    localparam int unsigned CW = $clog2(TICKS + 1);
    localparam logic [CW-1:0] LOADV = CW'(TICKS);

    logic [CW-1:0] left_q;

    assign busy = (left_q != '0);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            left_q <= '0;
        end else if (load) begin
            left_q <= LOADV;
        end else if (tick && busy) begin
            left_q <= left_q - 1'b1;
        end
    end

    // R10: a load always opens a window on the next cycle
    assert_load_opens_R10: assert property (@(posedge clk) disable iff (rst)
        (load && !clear) |=> busy);

    // R4: the window only shrinks on a tick
    assert_shrink_on_tick_R4: assert property (@(posedge clk) disable iff (rst)
        (busy && !tick && !load && !clear) |=> busy);

endmodule

// File: rtl/pwrsup_softstart.sv
module pwrsup_softstart #(
    parameter int unsigned STEPS      = 4,
    parameter int unsigned STEP_TICKS = 128
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clear,
    input  logic                     tick,
    output logic [$clog2(STEPS)-1:0] step_o,
    output logic                     done_o
);
    localparam int unsigned SW = $clog2(STEPS);
    localparam int unsigned TW = (STEP_TICKS > 1) ? $clog2(STEP_TICKS) : 1;
    localparam logic [SW-1:0] STEP_LAST = SW'(STEPS - 1);
    localparam logic [TW-1:0] TICK_LAST = TW'(STEP_TICKS - 1);

    logic [TW-1:0] tick_q;
    logic [SW-1:0] step_q;
    logic          done_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            tick_q <= '0;
            step_q <= '0;
            done_q <= 1'b0;
        end else if (tick && !done_q) begin
            if (tick_q == TICK_LAST) begin
                tick_q <= '0;
                if (step_q == STEP_LAST) begin
                    done_q <= 1'b1;
                end else begin
                    step_q <= step_q + 1'b1;
                end
            end else begin
                tick_q <= tick_q + 1'b1;
            end
        end
    end

    assign step_o = step_q;
    assign done_o = done_q;

    // R2: the current-limit step never goes down while enabled
    assert_step_monotonic_R2: assert property (@(posedge clk) disable iff (rst)
        !clear |=> (clear || step_q >= $past(step_q)));

    // R3: soft-start only ends at full current limit
    assert_done_at_full_R3: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (step_q == STEP_LAST));

endmodule

// File: rtl/pwr_supervisor.sv
module pwr_supervisor
    import pwrsup_pkg::*;
#(
    parameter int unsigned CLK_HZ          = 125_000_000,
    parameter int unsigned VSEL_W          = 2,
    parameter int unsigned SS_STEPS        = 4,
    parameter int unsigned SS_STEP_TICKS   = 128,
    parameter int unsigned UV_BLANK_TICKS  = 512,
    parameter int unsigned VSEL_MASK_TICKS = 32,
    parameter int unsigned OV_DLY_TENTHS   = 200,
    parameter int unsigned UV_DLY_TENTHS   = 25,
    parameter int unsigned PG_DLY_TENTHS   = 25
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        sw_tick_i,
    input  logic                        en_i,
    input  logic                        uvlo_i,
    input  logic [VSEL_W-1:0]           vsel_i,
    input  logic                        ovr_i,
    input  logic                        udr_i,
    input  logic                        below_lo_i,
    input  logic                        above_hi_i,
    output logic                        pgood_o,
    output logic [$clog2(SS_STEPS)-1:0] ilim_step_o,
    output logic                        ls_force_o,
    output logic                        gates_low_o,
    output logic [1:0]                  fault_code_o
);
    localparam int unsigned OV_CYC = tenths_us_to_cycles(CLK_HZ, OV_DLY_TENTHS);
    localparam int unsigned UV_CYC = tenths_us_to_cycles(CLK_HZ, UV_DLY_TENTHS);
    localparam int unsigned PG_CYC = tenths_us_to_cycles(CLK_HZ, PG_DLY_TENTHS);

    fb_win_t fb;
    assign fb = '{ov: ovr_i, uv: udr_i, below_lo: below_lo_i, above_hi: above_hi_i};

    logic active;
    assign active = en_i & ~uvlo_i;

    // ---------------- voltage-select change detection and mask ----------------
    logic [VSEL_W-1:0] vsel_q;
    logic              vsel_chg;
    logic              mask_busy;
    logic              freeze;

    always_ff @(posedge clk) begin
        vsel_q <= vsel_i;
    end

    assign vsel_chg = (vsel_i != vsel_q);

    pwrsup_tick_timer #(.TICKS(VSEL_MASK_TICKS)) i_mask_timer (
        .clk   (clk),
        .rst   (rst),
        .clear (~active),
        .load  (vsel_chg),
        .tick  (sw_tick_i),
        .busy  (mask_busy)
    );

    assign freeze = vsel_chg | mask_busy;

    // ---------------- under-voltage blanking after enable ----------------
    logic blank_busy;

    pwrsup_tick_timer #(.TICKS(UV_BLANK_TICKS)) i_blank_timer (
        .clk   (clk),
        .rst   (1'b0),
        .clear (1'b0),
        .load  (rst | ~active),
        .tick  (sw_tick_i),
        .busy  (blank_busy)
    );

    // ---------------- soft-start current-limit stepping ----------------
    logic ss_done;

    pwrsup_softstart #(
        .STEPS      (SS_STEPS),
        .STEP_TICKS (SS_STEP_TICKS)
    ) i_softstart (
        .clk    (clk),
        .rst    (rst),
        .clear  (~active),
        .tick   (sw_tick_i),
        .step_o (ilim_step_o),
        .done_o (ss_done)
    );

    // ---------------- fault detection and latch ----------------
    fault_e fault_q;
    logic   no_fault;
    logic   ov_qual, uv_qual;
    logic   ov_fire, uv_fire;

    assign no_fault = (fault_q == FLT_NONE);
    assign ov_qual  = active & no_fault & ~freeze & fb.ov;
    assign uv_qual  = active & no_fault & ~freeze & ~blank_busy & fb.uv;

    pwrsup_deglitch #(.CYCLES(OV_CYC)) i_ov_dg (
        .clk   (clk),
        .rst   (rst),
        .clear (~active),
        .cond  (ov_qual),
        .fire  (ov_fire)
    );

    pwrsup_deglitch #(.CYCLES(UV_CYC)) i_uv_dg (
        .clk   (clk),
        .rst   (rst),
        .clear (~active),
        .cond  (uv_qual),
        .fire  (uv_fire)
    );

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            fault_q <= FLT_NONE;
        end else if (no_fault) begin
            if (ov_fire) begin
                fault_q <= FLT_OV;
            end else if (uv_fire) begin
                fault_q <= FLT_UV;
            end
        end
    end

    // ---------------- power-good with hysteresis and deglitch ----------------
    logic pg_q;
    logic pg_want;
    logic pg_cond;
    logic pg_fire;

    always_comb begin
        if (pg_q) begin
            pg_want = ~(fb.ov | fb.below_lo);
        end else begin
            pg_want = fb.above_hi & ~fb.ov;
        end
        pg_want = pg_want & ss_done & no_fault;
    end

    assign pg_cond = active & ss_done & no_fault & ~freeze & (pg_want != pg_q);

    pwrsup_deglitch #(.CYCLES(PG_CYC)) i_pg_dg (
        .clk   (clk),
        .rst   (rst),
        .clear (~active),
        .cond  (pg_cond),
        .fire  (pg_fire)
    );

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            pg_q <= 1'b0;
        end else if (!ss_done || !no_fault) begin
            pg_q <= 1'b0;
        end else if (!freeze && pg_fire) begin
            pg_q <= ~pg_q;
        end
    end

    // ---------------- outputs ----------------
    assign pgood_o      = pg_q;
    assign fault_code_o = fault_q;
    assign ls_force_o   = (fault_q == FLT_OV);
    assign gates_low_o  = ~en_i | uvlo_i | (fault_q == FLT_UV);

    // ---------------- assertions ----------------
    // R1: reset leaves power-good low and no fault
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (!pg_q && fault_q == FLT_NONE));

    // R3: power-good only rises after soft-start
    assert_pg_after_ss_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(pg_q) |-> ss_done);

    // R5: an over-voltage latch follows an over-voltage flag
    assert_ov_from_flag_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(fault_q == FLT_OV) |-> $past(fb.ov));

    // R4: no under-voltage latch out of the blanking window
    assert_uv_not_blanked_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(fault_q == FLT_UV) |-> $past(fb.uv && !blank_busy));

    // R7: a latched fault holds while enabled
    assert_fault_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (fault_q != FLT_NONE && active) |=> (!active || fault_q == $past(fault_q)));

    // R10: power-good is frozen while the select mask is open
    assert_pg_frozen_R10: assert property (@(posedge clk) disable iff (rst)
        (freeze && ss_done && no_fault && active) |=> (!active || pg_q == $past(pg_q)));

    // R12: a latched fault pulls power-good low on the next cycle
    assert_fault_drops_pg_R12: assert property (@(posedge clk) disable iff (rst)
        (fault_q != FLT_NONE) |=> !pg_q);

endmodule

// File: tb/test_pwr_supervisor.sv
module test_pwr_supervisor;

    localparam int unsigned CLK_HZ = 8_000_000;
    localparam int OV_N  = CLK_HZ / 50_000;   // 20 us
    localparam int UV_N  = CLK_HZ / 400_000;  // 2.5 us
    localparam int PG_N  = CLK_HZ / 400_000;  // 2.5 us
    localparam int STEPT = 128;
    localparam int BLANK = 512;
    localparam int MASK  = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic en = 1'b0;
    logic uvlo = 1'b0;
    logic [1:0] vsel = 2'd0;
    logic ovf = 1'b0, uvf = 1'b0, b90 = 1'b1, a93 = 1'b0;

    logic       pgood, ls_force, gates_low;
    logic [1:0] step, fault;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    pwr_supervisor #(.CLK_HZ(CLK_HZ)) i_pwr_supervisor (
        .clk          (clk),
        .rst          (rst),
        .sw_tick_i    (tick),
        .en_i         (en),
        .uvlo_i       (uvlo),
        .vsel_i       (vsel),
        .ovr_i        (ovf),
        .udr_i        (uvf),
        .below_lo_i   (b90),
        .above_hi_i   (a93),
        .pgood_o      (pgood),
        .ilim_step_o  (step),
        .ls_force_o   (ls_force),
        .gates_low_o  (gates_low),
        .fault_code_o (fault)
    );

    // ---------------- reference model built from the requirements ----------------
    int   m_ss = 0, m_step = 0, m_blank = 0, m_mask = 0;
    int   m_ovc = 0, m_uvc = 0, m_pgc = 0, m_fault = 0;
    bit   m_done = 0, m_pg = 0;
    logic [1:0] m_vsel = 2'd0;

    always @(posedge clk) begin : ref_model
        bit act, chg, frz, blank, nf, ovq, uvq, fov, fuv, want, pc, pf;
        act   = en && !uvlo;
        chg   = (vsel != m_vsel);
        frz   = chg || (m_mask != 0);
        blank = (m_blank != 0);
        nf    = (m_fault == 0);
        ovq   = act && nf && !frz && ovf;
        uvq   = act && nf && !frz && !blank && uvf;
        fov   = ovq && (m_ovc == OV_N - 1);
        fuv   = uvq && (m_uvc == UV_N - 1);
        if (m_pg) want = !(ovf || b90); else want = a93 && !ovf;
        want  = want && m_done && nf;
        pc    = act && m_done && nf && !frz && (want != m_pg);
        pf    = pc && (m_pgc == PG_N - 1);

        if (rst || !act) m_pg = 0;
        else if (!m_done || !nf) m_pg = 0;
        else if (!frz && pf) m_pg = !m_pg;

        if (rst || !act) m_fault = 0;
        else if (nf) begin
            if (fov) m_fault = 1;
            else if (fuv) m_fault = 2;
        end

        m_ovc = (rst || !act || !ovq || fov) ? 0 : m_ovc + 1;
        m_uvc = (rst || !act || !uvq || fuv) ? 0 : m_uvc + 1;
        m_pgc = (rst || !act || !pc || pf) ? 0 : m_pgc + 1;

        if (rst || !act) m_mask = 0;
        else if (chg) m_mask = MASK;
        else if (tick && m_mask != 0) m_mask = m_mask - 1;

        if (rst || !act) m_blank = BLANK;
        else if (tick && m_blank != 0) m_blank = m_blank - 1;

        if (rst || !act) begin
            m_ss = 0; m_step = 0; m_done = 0;
        end else if (tick && !m_done) begin
            if (m_ss == STEPT - 1) begin
                m_ss = 0;
                if (m_step == 3) m_done = 1; else m_step = m_step + 1;
            end else m_ss = m_ss + 1;
        end
        m_vsel = vsel;
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input string tag, input int act_v, input int exp_v);
        n_chk++;
        if (act_v != exp_v) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act_v, exp_v, $time);
        end
    endtask

    task automatic compare_model();
        chk("R8/R9 model pgood", int'(pgood), int'(m_pg));
        chk("R2 model step", int'(step), m_step);
        chk("R7 model fault", int'(fault), m_fault);
        chk("R5 model ls_force", int'(ls_force), int'(m_fault == 1));
        chk("R11 model gates_low", int'(gates_low), int'(!en || uvlo || m_fault == 2));
    endtask

    task automatic cyc(input logic t);
        tick = t;
        @(negedge clk);
        compare_model();
    endtask

    task automatic ticks(input int n, input int gap);
        repeat (n) begin
            cyc(1'b1);
            repeat (gap - 1) cyc(1'b0);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) cyc(1'b0);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200_000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        int unsigned seed;
        int lvl;
        seed = $urandom(32'd20240611);
        @(negedge clk);
        idle(4);
        chk("R1 reset pgood", int'(pgood), 0);
        chk("R1 reset step", int'(step), 0);
        chk("R1 reset fault", int'(fault), 0);
        chk("R11 gates low while disabled", int'(gates_low), 1);
        rst = 1'b0;
        idle(2);

        // Soft-start, blanking and power-good rise
        en = 1'b1; b90 = 1'b0; a93 = 1'b1; uvf = 1'b1;
        ticks(127, 2);
        chk("R2 step before 128 ticks", int'(step), 0);
        ticks(1, 2);
        chk("R2 step after 128 ticks", int'(step), 1);
        ticks(256, 2);
        chk("R2 step after 384 ticks", int'(step), 3);
        chk("R4 uv ignored during blanking", int'(fault), 0);
        ticks(127, 2);
        chk("R3 pgood held in soft-start", int'(pgood), 0);
        chk("R4 uv ignored at tick 511", int'(fault), 0);
        uvf = 1'b0;
        ticks(1, 2);
        chk("R2 step stays at full", int'(step), 3);
        idle(PG_N - 2);
        chk("R8 pgood one clock before deglitch", int'(pgood), 0);
        idle(1);
        chk("R8 pgood after deglitch", int'(pgood), 1);
        a93 = 1'b0;
        idle(50);
        chk("R8 pgood kept in 90-93 band", int'(pgood), 1);

        // Power-good falling deglitch
        b90 = 1'b1;
        idle(PG_N - 1);
        chk("R9 short dip ignored", int'(pgood), 1);
        b90 = 1'b0;
        idle(1);
        b90 = 1'b1;
        idle(PG_N - 1);
        chk("R9 count restarts after dip", int'(pgood), 1);
        idle(1);
        chk("R9 pgood falls after deglitch", int'(pgood), 0);
        b90 = 1'b0; a93 = 1'b1;
        idle(PG_N);
        chk("R8 pgood recovers", int'(pgood), 1);

        // Over-voltage run one clock short
        ovf = 1'b1;
        idle(OV_N - 1);
        chk("R5 short ov run no latch", int'(fault), 0);
        ovf = 1'b0;
        idle(1);
        chk("R5 ov count restarts", int'(fault), 0);
        idle(PG_N + 2);
        chk("R8 pgood back before uv test", int'(pgood), 1);

        // Under-voltage latch and power-good drop
        uvf = 1'b1;
        idle(UV_N - 1);
        chk("R6 uv one clock short", int'(fault), 0);
        idle(1);
        chk("R6 uv latched", int'(fault), 2);
        chk("R6 gates low on uv", int'(gates_low), 1);
        idle(1);
        chk("R12 pgood low after fault", int'(pgood), 0);
        uvf = 1'b0; ovf = 1'b1;
        idle(OV_N + 10);
        chk("R7 first fault kept", int'(fault), 2);
        chk("R7 no ls force over uv fault", int'(ls_force), 0);
        en = 1'b0;
        idle(1);
        chk("R7 disable clears fault", int'(fault), 0);
        chk("R1 disabled pgood", int'(pgood), 0);
        chk("R1 disabled step", int'(step), 0);
        chk("R11 gates low on disable", int'(gates_low), 1);
        ovf = 1'b0;

        // Re-enable, then voltage-select mask with restart
        en = 1'b1; a93 = 1'b1; b90 = 1'b0;
        ticks(BLANK, 2);
        idle(PG_N + 2);
        chk("R8 pgood after re-enable", int'(pgood), 1);
        chk("R11 gates released", int'(gates_low), 0);
        vsel = 2'd1;
        idle(1);
        b90 = 1'b1; a93 = 1'b0; ovf = 1'b1;
        ticks(20, 6);
        chk("R10 pgood frozen", int'(pgood), 1);
        vsel = 2'd3;
        idle(1);
        ticks(MASK - 1, 6);
        chk("R10 pgood frozen after restart", int'(pgood), 1);
        chk("R10 ov masked", int'(fault), 0);
        ovf = 1'b0; b90 = 1'b0; a93 = 1'b1;
        ticks(1, 2);
        ovf = 1'b1;
        idle(OV_N - 1);
        chk("R5 ov one clock short", int'(fault), 0);
        idle(1);
        chk("R5 ov latched", int'(fault), 1);
        chk("R5 low side forced", int'(ls_force), 1);
        idle(1);
        chk("R12 pgood low after ov", int'(pgood), 0);
        ovf = 1'b0; uvf = 1'b1;
        idle(UV_N + 10);
        chk("R7 ov fault kept over uv", int'(fault), 1);
        uvf = 1'b0;
        uvlo = 1'b1;
        idle(1);
        chk("R7 uvlo clears fault", int'(fault), 0);
        chk("R11 gates low on uvlo", int'(gates_low), 1);
        chk("R1 uvlo pgood", int'(pgood), 0);
        uvlo = 1'b0;
        idle(2);

        // Constrained random phase checked against the model
        lvl = 3;
        for (int i = 0; i < 30000; i++) begin
            if ($urandom % 150 == 0) lvl = int'($urandom % 5);
            uvf = (lvl == 0);
            b90 = (lvl <= 1);
            a93 = (lvl >= 3);
            ovf = (lvl == 4);
            if ($urandom % 400 == 0) vsel = 2'($urandom);
            if ($urandom % 6000 == 0) en = 1'b0;
            else if (!en && $urandom % 8 == 0) en = 1'b1;
            uvlo = ($urandom % 9000 == 0);
            cyc(($urandom % 3) == 0);
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule